// File: doc/BRIEF.md
# Serial Register Write Port

This block is the slave side of a three-wire serial control link: an active-low select, a bit clock and a data input. A host uses it to write a bank of configuration registers. The serial pins are brought into the core clock domain through synchronizers. Bits are taken on rising bit-clock edges and assembled into bytes. Each frame is parsed in a fixed order: a header byte that carries the device identity and a direction bit, then a pointer byte, then any number of data bytes. Every data byte leaves the block as one register write on a valid/ready stream of address and data.

The pointer byte sets the target register. Its top bit decides whether the target moves up by one after every data byte or stays on the same register. The link is write-only, so the block has no serial output pin. Any frame that is not a write to this device is dropped until the select is released. A byte that is cut short by the select rising produces nothing.

Back-pressure rules for the write stream: a write is offered with `wr_valid` high and holds its address and data until the cycle in which `wr_ready` is high. The serial side cannot be stalled. If a new byte completes while a write is still waiting, that new write is discarded and the waiting one is kept. When a byte completes in the same cycle that the waiting write is accepted, the new byte takes the freed slot.

Top module: `spi_regwr_port`

## Requirements
- R1: Serial data is sampled on rising edges of `ser_clk` only while `ser_cs_n` is low, most significant bit first, and eight samples form one byte.
- R2: Bits 7..1 of the first byte must equal the device identity 7'b0010000 (header byte 8'h20 for a write). On any other value, no write is produced for the rest of the frame.
- R3: Bit 0 of the first byte is the direction flag. When it is 1, no write is produced for the rest of the frame.
- R4: In the second byte, bits 6..0 give the register address used by the first data byte that follows.
- R5: If bit 7 of the second byte is 1, the address advances by one after each data byte and wraps from 127 to 0.
- R6: If bit 7 of the second byte is 0, every data byte of the frame goes to the same address.
- R7: When `ser_cs_n` rises partway through a byte, that partial byte produces no write.
- R8: A rising edge of `ser_cs_n` clears the bit count and the frame state, so the next frame is parsed again from its header byte.
- R9: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold their values.
- R10: A data byte that completes while an earlier write is still waiting is discarded, and the waiting write is kept.
- R11: After reset `wr_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_cs_n | input | 1 | Serial select, active low, asynchronous to `clk` |
| ser_clk | input | 1 | Serial bit clock, idles low, asynchronous to `clk` |
| ser_din | input | 1 | Serial data in, changes while `ser_clk` is low |
| wr_valid | output | 1 | A register write is offered |
| wr_ready | input | 1 | The consumer accepts the offered write |
| wr_addr | output | 7 | Register address of the offered write |
| wr_data | output | 8 | Data of the offered write |

## Verification
Two situations are the hardest to reach from the ports. The first is a write being dropped under back-pressure. The bench holds `wr_ready` low through a frame with several data bytes, so the second and third bytes complete while the first write is still waiting. It then checks that only the first write comes out, unchanged. The second is the pointer wrapping. A frame with increment enabled starts at address 126 and carries four data bytes, which drives the address across 127 into 0 and 1. Frames cut after 3 or 29 bits exercise the partial-byte and reset paths. A slowly toggling `wr_ready` checks the hold rule without losing any writes.

// File: rtl/spi_regwr_pkg.sv
package spi_regwr_pkg;
  typedef enum logic [1:0] {
    FR_HDR  = 2'd0,
    FR_PTR  = 2'd1,
    FR_DATA = 2'd2,
    FR_SKIP = 2'd3
  } frame_state_t;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned BIT_CNT_W = $clog2(BYTE_W);
endpackage

// File: rtl/spi_regwr_sync.sv
module spi_regwr_sync #(
  parameter int unsigned WIDTH = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else        chain[s] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/spi_regwr_deser.sv
module spi_regwr_deser
  import spi_regwr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              sck_s,
  input  logic              din_s,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_val,
  output logic              frame_end
);
  localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);
  localparam logic [BIT_CNT_W-1:0] CNT_ONE  = BIT_CNT_W'(1);

  logic                 sck_d;
  logic                 cs_d;
  logic                 sck_rise;
  logic [BIT_CNT_W-1:0] bit_cnt;
  logic [BYTE_W-2:0]    shreg;

  assign sck_rise  = sck_s && !sck_d && !cs_n_s;
  assign frame_end = cs_n_s && !cs_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      sck_d <= sck_s;
      cs_d  <= cs_n_s;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      shreg     <= '0;
      byte_done <= 1'b0;
      byte_val  <= '0;
    end else begin
      byte_done <= 1'b0;
      if (cs_n_s) begin
        bit_cnt <= '0;
      end else if (sck_rise) begin
        shreg   <= {shreg[BYTE_W-3:0], din_s};
        bit_cnt <= bit_cnt + CNT_ONE;
        if (bit_cnt == LAST_BIT) begin
          byte_done <= 1'b1;
          byte_val  <= {shreg, din_s};
        end
      end
    end
  end

  // R8: the bit count starts over after every select release
  assert_count_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (bit_cnt == '0));

  // R1/R7: no byte is reported while the select is high
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_s && $past(cs_n_s)) |=> !byte_done);
endmodule

// File: rtl/spi_regwr_frame.sv
module spi_regwr_frame
  import spi_regwr_pkg::*;
#(
  parameter int unsigned PTR_W = 7,
  parameter logic [6:0]  DEV_ID = 7'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic              frame_end,
  output logic              push,
  output logic [PTR_W-1:0]  push_addr,
  output logic [BYTE_W-1:0] push_data
);
  localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);

  frame_state_t     state;
  logic [PTR_W-1:0] ptr;
  logic             incr;
  logic             hdr_ok;

  assign hdr_ok = (byte_val[7:1] == DEV_ID) && !byte_val[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= FR_HDR;
      ptr       <= '0;
      incr      <= 1'b0;
      push      <= 1'b0;
      push_addr <= '0;
      push_data <= '0;
    end else begin
      push <= 1'b0;
      if (frame_end) begin
        state <= FR_HDR;
      end else if (byte_done) begin
        unique case (state)
          FR_HDR:  state <= hdr_ok ? FR_PTR : FR_SKIP;
          FR_PTR: begin
            ptr   <= byte_val[PTR_W-1:0];
            incr  <= byte_val[7];
            state <= FR_DATA;
          end
          FR_DATA: begin
            push      <= 1'b1;
            push_addr <= ptr;
            push_data <= byte_val;
            if (incr) ptr <= ptr + PTR_ONE;
          end
          FR_SKIP: state <= FR_SKIP;
          default: state <= FR_HDR;
        endcase
      end
    end
  end

  // R2/R3: a rejected frame never produces a write
  assert_skip_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == FR_SKIP) |=> !push);

  // R5: increment mode moves the pointer by one per written byte
  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !frame_end && state == FR_DATA && incr) |=> (ptr == push_addr + PTR_ONE));

  // R6: fixed mode keeps the pointer on the same register
  assert_ptr_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !frame_end && state == FR_DATA && !incr) |=> (ptr == push_addr));

  // R8: select release always brings the parser back to the header
  assert_frame_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (state == FR_HDR));
endmodule

// File: rtl/spi_regwr_outq.sv
module spi_regwr_outq
  import spi_regwr_pkg::*;
#(
  parameter int unsigned PTR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [PTR_W-1:0]  push_addr,
  input  logic [BYTE_W-1:0] push_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PTR_W-1:0]  out_addr,
  output logic [BYTE_W-1:0] out_data
);
  logic slot_free;

  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_data  <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (push && slot_free) begin
        out_valid <= 1'b1;
        out_addr  <= push_addr;
        out_data  <= push_data;
      end
    end
  end

  // R9: an offered write holds until accepted
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_data)));

  // R10: a byte arriving against a waiting write does not replace it
  assert_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && push) |=> ($stable(out_data) && $stable(out_addr)));
endmodule

// File: rtl/spi_regwr_port.sv
module spi_regwr_port
  import spi_regwr_pkg::*;
#(
  parameter int unsigned PTR_W = 7,
  parameter logic [6:0]  DEV_ID = 7'h10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_cs_n,
  input  logic              ser_clk,
  input  logic              ser_din,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [PTR_W-1:0]  wr_addr,
  output logic [BYTE_W-1:0] wr_data
);
  logic              cs_n_s, sck_s, din_s;
  logic              byte_done, frame_end;
  logic [BYTE_W-1:0] byte_val;
  logic              push;
  logic [PTR_W-1:0]  push_addr;
  logic [BYTE_W-1:0] push_data;

  spi_regwr_sync #(
    .WIDTH   (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({ser_cs_n, ser_clk, ser_din}),
    .sync_out ({cs_n_s, sck_s, din_s})
  );

  spi_regwr_deser u_deser (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n_s    (cs_n_s),
    .sck_s     (sck_s),
    .din_s     (din_s),
    .byte_done (byte_done),
    .byte_val  (byte_val),
    .frame_end (frame_end)
  );

  spi_regwr_frame #(
    .PTR_W  (PTR_W),
    .DEV_ID (DEV_ID)
  ) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_done (byte_done),
    .byte_val  (byte_val),
    .frame_end (frame_end),
    .push      (push),
    .push_addr (push_addr),
    .push_data (push_data)
  );

  spi_regwr_outq #(
    .PTR_W (PTR_W)
  ) u_outq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_addr (push_addr),
    .push_data (push_data),
    .out_valid (wr_valid),
    .out_ready (wr_ready),
    .out_addr  (wr_addr),
    .out_data  (wr_data)
  );
endmodule

// File: tb/test_spi_regwr_port.sv
module test_spi_regwr_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCK = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_cs_n = 1'b1;
  logic       ser_clk = 1'b0;
  logic       ser_din = 1'b0;
  logic       wr_valid;
  logic       wr_ready;
  logic [6:0] wr_addr;
  logic [7:0] wr_data;

  int checks = 0;
  int errors = 0;
  int ready_mode = 0;  // 0 high, 1 toggling, 2 low
  int tog_cnt = 0;
  string cur_tag = "R11";
  logic [7:0]  fbuf [16];
  logic [14:0] exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_regwr_port i_spi_regwr_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .ser_cs_n (ser_cs_n),
    .ser_clk  (ser_clk),
    .ser_din  (ser_din),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

  always @(posedge clk) begin
    tog_cnt <= tog_cnt + 1;
    if (ready_mode == 0)      wr_ready <= 1'b1;
    else if (ready_mode == 2) wr_ready <= 1'b0;
    else if (tog_cnt % 3 == 0) wr_ready <= ~wr_ready;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compare every accepted write with the scoreboard
  always @(negedge clk) begin
    if (rst_n && wr_valid && wr_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, {cur_tag, " unexpected write"}, {wr_addr, wr_data}, 0);
      end else begin
        logic [14:0] e;
        e = exp_q.pop_front();
        check({wr_addr, wr_data} == e, cur_tag, {wr_addr, wr_data}, e);
      end
    end
  end

  // expected writes computed from the frame rules
  task automatic model_frame(input int nbits, input bit hold);
    int nb;
    logic [6:0] p;
    bit inc;
    nb = nbits / 8;
    if (nb < 2) return;
    if (fbuf[0][7:1] != 7'h10 || fbuf[0][0]) return;
    p = fbuf[1][6:0];
    inc = fbuf[1][7];
    for (int i = 2; i < nb; i++) begin
      if (!(hold && i > 2)) exp_q.push_back({p, fbuf[i]});
      if (inc) p = p + 7'd1;
    end
  endtask

  task automatic send(input int nbits, input bit hold, input string tag);
    cur_tag = tag;
    model_frame(nbits, hold);
    ser_cs_n = 1'b0;
    #(HALF_SCK);
    for (int b = 0; b < nbits; b++) begin
      ser_din = fbuf[b/8][7 - (b % 8)];
      #(HALF_SCK);
      ser_clk = 1'b1;
      #(HALF_SCK);
      ser_clk = 1'b0;
    end
    #(HALF_SCK);
    ser_cs_n = 1'b1;
    #(HALF_SCK * 3);
  endtask

  task automatic drained(input string tag);
    repeat (30) @(negedge clk);
    check(exp_q.size() == 0, {tag, " writes missing"}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", checks);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    check(wr_valid == 1'b0, "R11 valid during reset", wr_valid, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(wr_valid == 1'b0, "R11 valid after reset", wr_valid, 0);

    // R1 R4 R6: fixed pointer
    fbuf[0] = 8'h20; fbuf[1] = 8'h05; fbuf[2] = 8'hA5; fbuf[3] = 8'h3C; fbuf[4] = 8'hFF;
    send(40, 1'b0, "R6 fixed address");
    drained("R6");

    // R5: increment with wrap 126,127,0,1
    fbuf[0] = 8'h20; fbuf[1] = 8'hFE; fbuf[2] = 8'h11; fbuf[3] = 8'h22; fbuf[4] = 8'h33; fbuf[5] = 8'h44;
    send(48, 1'b0, "R5 increment wrap");
    drained("R5");

    // R2: wrong device identity
    fbuf[0] = 8'h22; fbuf[1] = 8'h05; fbuf[2] = 8'h77;
    send(24, 1'b0, "R2 wrong identity");
    drained("R2");

    // R3: direction bit set
    fbuf[0] = 8'h21; fbuf[1] = 8'h05; fbuf[2] = 8'h66;
    send(24, 1'b0, "R3 read flag");
    drained("R3");

    // R7: partial trailing byte
    fbuf[0] = 8'h20; fbuf[1] = 8'h90; fbuf[2] = 8'h5A; fbuf[3] = 8'hF0;
    send(29, 1'b0, "R7 partial byte");
    drained("R7");

    // R8: aborted header, then a clean frame
    fbuf[0] = 8'h20;
    send(3, 1'b0, "R8 aborted header");
    fbuf[0] = 8'h20; fbuf[1] = 8'h03; fbuf[2] = 8'h99;
    send(24, 1'b0, "R8 restart");
    drained("R8");

    // R9: toggling ready, no loss
    ready_mode = 1;
    fbuf[0] = 8'h20; fbuf[1] = 8'h8A;
    for (int i = 2; i < 8; i++) fbuf[i] = 8'(8'h40 + i);
    send(64, 1'b0, "R9 toggling ready");
    drained("R9");

    // R10: ready held low, later bytes dropped
    ready_mode = 2;
    repeat (4) @(negedge clk);
    fbuf[0] = 8'h20; fbuf[1] = 8'h81; fbuf[2] = 8'h01; fbuf[3] = 8'h02; fbuf[4] = 8'h03;
    send(40, 1'b1, "R10 drop under back-pressure");
    repeat (10) @(negedge clk);
    check(wr_valid == 1'b1, "R9 write held", wr_valid, 1);
    check(wr_data == 8'h01, "R10 held data", wr_data, 8'h01);
    check(wr_addr == 7'h01, "R10 held address", wr_addr, 7'h01);
    ready_mode = 0;
    drained("R10");
    check(wr_valid == 1'b0, "R10 nothing after drop", wr_valid, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule